// File: doc/BRIEF.md
# I2C START/STOP Condition Timing Generator

This block produces the bus conditions that frame an I2C transfer: a START, a repeated START and a STOP. It controls two open-drain drive-low enables, one for SCL and one for SDA. Each interval of a condition is counted in system clock cycles. All intervals come from one 5-bit set value, and a mode bit picks short or long timing. A controller that shifts bytes and handles acknowledges issues one-cycle commands to this block. Each finished condition is reported with a one-cycle done pulse.

The intervals are derived from the even set value N. The SCL release interval is N/2+1 cycles, the setup interval is N+1 cycles and the hold interval is N/2 cycles. Long mode doubles all three. A repeated START lets a read with a 10-bit address turn the bus around after the address phase without a STOP in between.

The block also watches the bus lines themselves. A selector picks SDA or SCL, and a polarity bit picks the falling or the rising edge. A matching edge produces a one-cycle pin interrupt pulse.

Top module: `i2c_cond_gen`

## Requirements
- R1: During and directly after reset, neither line is driven low, and cond_done and pin_irq are 0.
- R2: A start command accepted at clock edge E0 releases both lines at E0. SDA is pulled low at edge E0+R and SCL is pulled low at edge E0+R+H, where R=N/2+1 and H=N/2 in short mode.
- R3: A stop command accepted at edge E0 pulls SDA low and releases SCL at E0. SDA is released at edge E0+S, where S=N+1 in short mode.
- R4: When long_mode is 1 at acceptance, R, H and S are each twice their short-mode values.
- R5: A set value of 0 is used as 2, and an odd set value N is used as N+1.
- R6: A restart command accepted at E0 releases SDA and holds SCL low at E0. SCL is released at E0+H, SDA is pulled low at E0+H+R, and SCL is pulled low at E0+H+R+H.
- R7: Commands that arrive while a condition is in progress are ignored. When several commands arrive together in idle, start wins over restart, and restart wins over stop.
- R8: The set value and mode are captured when a command is accepted. Changing them during a condition does not alter its timing.
- R9: cond_done is high for exactly one cycle. It rises at the same edge as the final line change of each condition.
- R10: pin_irq pulses for one cycle after the first clock edge that samples an edge of the selected line (SDA when irq_sel_scl=0, SCL when 1) in the chosen direction (falling when irq_pol_rise=0, rising when 1). Edges in the other direction and edges on the other line produce no pulse.
- R11: SDA is only ever pulled low while SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_set | input | 5 | Condition timing set value N |
| long_mode | input | 1 | 0 short timing, 1 long timing |
| cmd_start | input | 1 | Request a START condition |
| cmd_restart | input | 1 | Request a repeated START condition |
| cmd_stop | input | 1 | Request a STOP condition |
| irq_sel_scl | input | 1 | Pin interrupt source: 0 SDA, 1 SCL |
| irq_pol_rise | input | 1 | Pin interrupt edge: 0 falling, 1 rising |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| cond_done | output | 1 | One-cycle pulse when a condition completes |
| pin_irq | output | 1 | One-cycle pin edge interrupt |

## Verification
The assertions assume that commands are single-cycle pulses sampled at a clock edge. They also assume that the bus level inputs are already synchronous to clk, so each change is seen at exactly one edge. The bench meets both assumptions: it changes every input on the falling clock edge and holds each command for exactly one rising edge. It applies odd and zero set values on purpose, because the block rounds them up rather than assuming legal input.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESTART_SDA,
        ST_RELEASE,
        ST_HOLD,
        ST_SETUP
    } cond_state_e;

endpackage

// File: rtl/i2c_cond_intervals.sv
module i2c_cond_intervals #(
    parameter int SET_W = 5
) (
    input  logic [SET_W-1:0]   set_val,
    input  logic               long_sel,
    output logic [SET_W+1:0]   t_rel,
    output logic [SET_W+1:0]   t_setup,
    output logic [SET_W+1:0]   t_hold
);
    localparam int TW = SET_W + 2;

    logic [SET_W:0]  eff;
    logic [TW-1:0]   rel_s;
    logic [TW-1:0]   setup_s;
    logic [TW-1:0]   hold_s;

    // Round illegal (zero or odd) values up to the next even value.
    always_comb begin
        if (set_val == '0) begin
            eff = (SET_W+1)'(2);
        end else begin
            eff = {1'b0, set_val} + {{SET_W{1'b0}}, set_val[0]};
        end
        hold_s  = {2'b00, eff[SET_W:1]};
        rel_s   = {2'b00, eff[SET_W:1]} + TW'(1);
        setup_s = {1'b0, eff} + TW'(1);
    end

    // Long mode doubles every interval.
    always_comb begin
        if (long_sel) begin
            t_rel   = rel_s << 1;
            t_setup = setup_s << 1;
            t_hold  = hold_s << 1;
        end else begin
            t_rel   = rel_s;
            t_setup = setup_s;
            t_hold  = hold_s;
        end
    end

endmodule

// File: rtl/i2c_cond_pinirq.sv
module i2c_cond_pinirq (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sel_scl,
    input  logic pol_rise,
    output logic irq
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic irq;
    } irq_regs_t;

    irq_regs_t irq_d, irq_q;

    always_comb begin
        logic now_v;
        logic was_v;
        irq_d          = irq_q;
        now_v          = sel_scl ? scl_in : sda_in;
        was_v          = sel_scl ? irq_q.scl_prev : irq_q.sda_prev;
        irq_d.irq      = (now_v != was_v) && (now_v == pol_rise);
        irq_d.scl_prev = scl_in;
        irq_d.sda_prev = sda_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, irq: 1'b0};
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q.irq;

    // R10: a pulse means the selected line now sits at the active level
    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q.irq |-> (($past(sel_scl) ? irq_q.scl_prev : irq_q.sda_prev) == $past(pol_rise)));

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
    parameter int SET_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] cond_set,
    input  logic             long_mode,
    input  logic             cmd_start,
    input  logic             cmd_restart,
    input  logic             cmd_stop,
    input  logic             irq_sel_scl,
    input  logic             irq_pol_rise,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             cond_done,
    output logic             pin_irq
);
    import i2c_cond_pkg::*;

    localparam int TW    = SET_W + 2;
    localparam int MAX_T = 2 * ((1 << SET_W) + 1);

    typedef struct packed {
        cond_state_e      st;
        logic [TW-1:0]    cnt;
        logic             scl_low;
        logic             sda_low;
        logic             done;
        logic [SET_W-1:0] set_lat;
        logic             long_lat;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic             idle;
    logic [SET_W-1:0] use_set;
    logic             use_long;
    logic [TW-1:0]    t_rel, t_setup, t_hold;

    assign idle     = (seq_q.st == ST_IDLE);
    assign use_set  = idle ? cond_set  : seq_q.set_lat;
    assign use_long = idle ? long_mode : seq_q.long_lat;

    i2c_cond_intervals #(.SET_W(SET_W)) i_intervals (
        .set_val  (use_set),
        .long_sel (use_long),
        .t_rel    (t_rel),
        .t_setup  (t_setup),
        .t_hold   (t_hold)
    );

    i2c_cond_pinirq i_pinirq (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sel_scl  (irq_sel_scl),
        .pol_rise (irq_pol_rise),
        .irq      (pin_irq)
    );

    always_comb begin
        logic last;
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        last       = (seq_q.cnt == '0);
        if (!last) begin
            seq_d.cnt = seq_q.cnt - TW'(1);
        end
        unique case (seq_q.st)
            ST_IDLE: begin
                if (cmd_start || cmd_restart || cmd_stop) begin
                    seq_d.set_lat  = cond_set;
                    seq_d.long_lat = long_mode;
                end
                if (cmd_start) begin
                    seq_d.st      = ST_RELEASE;
                    seq_d.scl_low = 1'b0;
                    seq_d.sda_low = 1'b0;
                    seq_d.cnt     = t_rel - TW'(1);
                end else if (cmd_restart) begin
                    seq_d.st      = ST_RESTART_SDA;
                    seq_d.scl_low = 1'b1;
                    seq_d.sda_low = 1'b0;
                    seq_d.cnt     = t_hold - TW'(1);
                end else if (cmd_stop) begin
                    seq_d.st      = ST_SETUP;
                    seq_d.scl_low = 1'b0;
                    seq_d.sda_low = 1'b1;
                    seq_d.cnt     = t_setup - TW'(1);
                end
            end
            ST_RESTART_SDA: begin
                if (last) begin
                    seq_d.st      = ST_RELEASE;
                    seq_d.scl_low = 1'b0;
                    seq_d.cnt     = t_rel - TW'(1);
                end
            end
            ST_RELEASE: begin
                if (last) begin
                    seq_d.st      = ST_HOLD;
                    seq_d.sda_low = 1'b1;
                    seq_d.cnt     = t_hold - TW'(1);
                end
            end
            ST_HOLD: begin
                if (last) begin
                    seq_d.st      = ST_IDLE;
                    seq_d.scl_low = 1'b1;
                    seq_d.done    = 1'b1;
                end
            end
            ST_SETUP: begin
                if (last) begin
                    seq_d.st      = ST_IDLE;
                    seq_d.sda_low = 1'b0;
                    seq_d.done    = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, scl_low: 1'b0, sda_low: 1'b0,
                       done: 1'b0, set_lat: '0, long_lat: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign scl_drive_low = seq_q.scl_low;
    assign sda_drive_low = seq_q.sda_low;
    assign cond_done     = seq_q.done;

    // R11: SDA is pulled low only while SCL is free
    p_sda_pull_scl_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.sda_low) |-> !seq_q.scl_low);

    // R9: done never lasts more than one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // R2 and R3: done coincides with the closing line change
    p_done_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> ($rose(seq_q.scl_low) || $fell(seq_q.sda_low)));

    // R8: captured timing stays put during a condition
    p_timing_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(seq_q.set_lat) && $stable(seq_q.long_lat)));

    // R4: the interval counter never exceeds the longest interval
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (seq_q.cnt < TW'(MAX_T)));

endmodule

// File: tb/test_i2c_cond_gen.sv
`timescale 1ns/1ps
module test_i2c_cond_gen;

    typedef struct packed {
        logic [4:0] n;
        logic       lng;
        logic [7:0] rel;
        logic [7:0] hold;
        logic [7:0] setup;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{n: 5'd30, lng: 1'b0, rel: 8'd16, hold: 8'd15, setup: 8'd31},
        '{n: 5'd4,  lng: 1'b0, rel: 8'd3,  hold: 8'd2,  setup: 8'd5},
        '{n: 5'd12, lng: 1'b1, rel: 8'd14, hold: 8'd12, setup: 8'd26},
        '{n: 5'd0,  lng: 1'b0, rel: 8'd2,  hold: 8'd1,  setup: 8'd3},
        '{n: 5'd7,  lng: 1'b0, rel: 8'd5,  hold: 8'd4,  setup: 8'd9},
        '{n: 5'd31, lng: 1'b1, rel: 8'd34, hold: 8'd32, setup: 8'd66},
        '{n: 5'd1,  lng: 1'b1, rel: 8'd4,  hold: 8'd2,  setup: 8'd6},
        '{n: 5'd10, lng: 1'b0, rel: 8'd6,  hold: 8'd5,  setup: 8'd11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cond_set = 5'd4;
    logic       long_mode = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_restart = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       irq_sel_scl = 1'b0;
    logic       irq_pol_rise = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       scl_drive_low, sda_drive_low, cond_done, pin_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_cond_gen i_i2c_cond_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .cond_set      (cond_set),
        .long_mode     (long_mode),
        .cmd_start     (cmd_start),
        .cmd_restart   (cmd_restart),
        .cmd_stop      (cmd_stop),
        .irq_sel_scl   (irq_sel_scl),
        .irq_pol_rise  (irq_pol_rise),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .cond_done     (cond_done),
        .pin_irq       (pin_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse commands for one rising edge; returns at the negedge right after it.
    task automatic issue(input logic s, input logic r, input logic p);
        @(negedge clk);
        cmd_start = s; cmd_restart = r; cmd_stop = p;
        @(negedge clk);
        cmd_start = 1'b0; cmd_restart = 1'b0; cmd_stop = 1'b0;
    endtask

    // Count negedges until the chosen drive (0 SDA, 1 SCL) equals target.
    task automatic watch(input int which, input logic target, output int n);
        n = 0;
        while (((which == 0) ? sda_drive_low : scl_drive_low) != target && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 scl in reset", int'(scl_drive_low), 0);
        chk("R1 sda in reset", int'(sda_drive_low), 0);
        chk("R1 done in reset", int'(cond_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", int'(pin_irq), 0);
        chk("R1 sda after reset", int'(sda_drive_low), 0);

        // Vector walk: start then stop per entry (R2 R3 R4 R5 R9)
        for (int v = 0; v < NVEC; v++) begin
            cond_set  = VECS[v].n;
            long_mode = VECS[v].lng;
            issue(1'b1, 1'b0, 1'b0);
            chk("R2 start releases sda", int'(sda_drive_low), 0);
            chk("R2 start releases scl", int'(scl_drive_low), 0);
            watch(0, 1'b1, n);
            chk("R2 R4 R5 release interval", n, int'(VECS[v].rel));
            watch(1, 1'b1, n);
            chk("R2 R4 R5 hold interval", n, int'(VECS[v].hold));
            chk("R9 done with scl pull", int'(cond_done), 1);
            @(negedge clk);
            chk("R9 done one cycle", int'(cond_done), 0);
            issue(1'b0, 1'b0, 1'b1);
            chk("R3 stop holds sda", int'(sda_drive_low), 1);
            chk("R3 stop frees scl", int'(scl_drive_low), 0);
            watch(0, 1'b0, n);
            chk("R3 R4 R5 setup interval", n, int'(VECS[v].setup));
            chk("R9 done on stop", int'(cond_done), 1);
        end

        // R8: timing change right after acceptance is not used
        cond_set = 5'd4; long_mode = 1'b0;
        issue(1'b1, 1'b0, 1'b0);
        cond_set = 5'd30; long_mode = 1'b1;
        watch(0, 1'b1, n);
        chk("R8 release uses captured value", n, 3);
        watch(1, 1'b1, n);
        chk("R8 hold uses captured value", n, 2);

        // R6: repeated start from the held bus, N=4 short
        cond_set = 5'd4; long_mode = 1'b0;
        issue(1'b0, 1'b1, 1'b0);
        chk("R6 restart frees sda", int'(sda_drive_low), 0);
        chk("R6 restart keeps scl low", int'(scl_drive_low), 1);
        watch(1, 1'b0, n);
        chk("R6 scl freed after hold", n, 2);
        watch(0, 1'b1, n);
        chk("R6 sda pulled after release", n, 3);
        watch(1, 1'b1, n);
        chk("R6 scl pulled after hold", n, 2);
        chk("R6 R9 done at restart end", int'(cond_done), 1);

        // R7: stop during a start is ignored
        cond_set = 5'd30;
        issue(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        watch(0, 1'b1, n);
        chk("R7 start unaffected by stop", n, 14);
        watch(1, 1'b1, n);
        chk("R7 hold unaffected by stop", n, 15);
        repeat (3) @(negedge clk);
        chk("R7 stop never ran scl", int'(scl_drive_low), 1);
        chk("R7 stop never ran sda", int'(sda_drive_low), 1);

        // R7: start wins over stop when both arrive in idle
        cond_set = 5'd4;
        issue(1'b1, 1'b0, 1'b1);
        chk("R7 priority sda released", int'(sda_drive_low), 0);
        watch(0, 1'b1, n);
        chk("R7 priority start timing", n, 3);
        watch(1, 1'b1, n);
        issue(1'b0, 1'b0, 1'b1);
        watch(0, 1'b0, n);
        chk("R3 closing stop", n, 5);

        // R10: pin interrupt selection and polarity
        @(negedge clk);
        irq_sel_scl = 1'b0; irq_pol_rise = 1'b0;
        sda_in = 1'b0;
        @(negedge clk);
        chk("R10 sda fall irq", int'(pin_irq), 1);
        sda_in = 1'b1;
        @(negedge clk);
        chk("R10 sda rise ignored", int'(pin_irq), 0);
        irq_sel_scl = 1'b1; irq_pol_rise = 1'b1;
        scl_in = 1'b0; sda_in = 1'b0;
        @(negedge clk);
        chk("R10 scl fall and sda ignored", int'(pin_irq), 0);
        scl_in = 1'b1;
        @(negedge clk);
        chk("R10 scl rise irq", int'(pin_irq), 1);
        @(negedge clk);
        chk("R10 irq one cycle", int'(pin_irq), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule